// File: doc/BRIEF.md
# Host SPI Framed Transaction Controller

This block is the host side of a half-duplex, framed SPI link to a co-processor. A local requester loads a command into an internal byte buffer and hands over its length with a valid/ready handshake. The controller then pulls an active-low select low and shifts the command out on a mode-0 SPI master that it contains. Once the command is sent, it polls with idle bytes (0xFF) until the peer answers with a byte that is not idle.

The controller works out the length of the response from its leading byte and, for payload frames, from its second byte. It clocks in exactly that many bytes, checks the closing byte, stores the response in a readable buffer and reports the result with a one-cycle done pulse and a 3-bit status. Between transactions it holds select high for a programmed number of cycles. It abandons a wait phase that outlasts a programmed limit. All timing limits are parameters in system-clock cycles.

Top module: `spi_xact_ctrl`

## Requirements
- R1: The serial link runs in SPI mode 0: SCLK is low whenever select is high, MOSI changes only while SCLK is low, bytes go most significant bit first, and consecutive rising SCLK edges within a byte are 2*CLK_HALF system cycles apart.
- R2: A request whose length is below 2 or above MAX_FRAME (136), or whose first command byte is 0xFF, is refused. The block pulses done with status 4 (bad request) in the cycle after the handshake, and select never goes low.
- R3: Bytes that arrive on MISO while the command is being sent do not affect the response, its length or its status.
- R4: After the last command byte, the controller sends 0xFF repeatedly. The first received byte that is not 0xFF is stored as response byte 0.
- R5: If only 0xFF has arrived once TIMEOUT_CYC cycles have passed since the end of the command, the transaction ends at the next byte boundary. The block reports status 3 (timeout) and a response length of 0, and releases select.
- R6: If response byte 0 is 0xFD or 0xFE, byte 1 is a payload length L and the response is L+3 bytes long. Otherwise it is exactly 3 bytes. The length is reported on rsp_len.
- R7: If the last response byte is not 0xA7, the block reports status 2 (bad terminator).
- R8: A well-terminated response whose byte 0 lies in 0x00..0x04 is a peer error code. It is clocked in completely and reported with status 1.
- R9: After each transaction, req_ready stays low and select stays high for GAP_CYC cycles. req_ready rises exactly GAP_CYC cycles after the done pulse.
- R10: A payload length byte above 133 marks the frame as corrupt. The controller ends the transaction right after that byte with status 2 and a response length of 2.
- R11: A well-terminated, non-error response ends with a single-cycle done pulse and status 0. Its bytes can be read back from rsp_rd_addr/rsp_rd_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr_en | input | 1 | Write strobe for the command buffer |
| cmd_wr_addr | input | 8 | Command buffer byte index |
| cmd_wr_data | input | 8 | Command byte to store |
| req_valid | input | 1 | Request to start a transaction |
| req_ready | output | 1 | Controller can accept a request |
| req_len | input | 8 | Number of command bytes |
| rsp_rd_addr | input | 8 | Response buffer byte index |
| rsp_rd_data | output | 8 | Response byte at rsp_rd_addr |
| rsp_len | output | 8 | Number of response bytes stored |
| done | output | 1 | One-cycle completion pulse |
| status | output | 3 | 0 ok, 1 error code, 2 bad terminator, 3 timeout, 4 bad request |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the peer |
| spi_miso | input | 1 | Serial data from the peer |
| spi_ss_n | output | 1 | Active-low select |

## Verification
A refused request shows done one cycle after the clock edge that takes the handshake. req_ready comes back exactly GAP_CYC cycles after a done pulse. Rising SCLK edges inside a byte come every 2*CLK_HALF cycles. The bench reads every output on the falling system-clock edge, so each registered result has settled a half cycle before it is compared. The peer model drives MISO on falling SCLK and records MOSI on rising SCLK. This lets the bench count bytes, and the cycles between select edges, in the same cycles the controller produces them.

// File: rtl/spi_xact_pkg.sv
package spi_xact_pkg;

  localparam logic [7:0] IDLE_BYTE    = 8'hFF;
  localparam logic [7:0] CLOSE_BYTE   = 8'hA7;
  localparam logic [7:0] KIND_BOOT    = 8'hFD;
  localparam logic [7:0] KIND_PAYLOAD = 8'hFE;
  localparam logic [7:0] LAST_ERRCODE = 8'h04;
  localparam logic [7:0] MAX_PAYLOAD  = 8'd133;

  typedef enum logic [2:0] {
    XS_OK      = 3'd0,
    XS_ERRCODE = 3'd1,
    XS_BADTERM = 3'd2,
    XS_TIMEOUT = 3'd3,
    XS_BADREQ  = 3'd4
  } xact_status_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_WAIT,
    ST_RESP
  } xact_state_e;

endpackage

// File: rtl/spi_frame_buf.sv
module spi_frame_buf #(
  parameter int DEPTH = 136,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  localparam logic [AW:0] DEPTH_W = (AW+1)'(DEPTH);

  logic [7:0] mem [DEPTH];
  logic       wr_hit;
  logic       rd_hit;

  assign wr_hit = wr_en && ({1'b0, wr_addr} < DEPTH_W);
  assign rd_hit = {1'b0, rd_addr} < DEPTH_W;

  always_ff @(posedge clk) begin
    if (wr_hit) begin
      mem[wr_addr] <= wr_data;
    end
  end

  assign rd_data = rd_hit ? mem[rd_addr] : 8'hFF;

endmodule

// File: rtl/spi_gap_timer.sv
module spi_gap_timer #(
  parameter int CYC = 200000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic idle
);

  localparam int W = $clog2(CYC + 1) + 1;
  localparam logic [W-1:0] LOAD_VAL = W'(CYC);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = LOAD_VAL;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign idle = (cnt_q == '0);

endmodule

// File: rtl/spi_byte_engine.sv
module spi_byte_engine #(
  parameter int HALF = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte,
  output logic       sclk,
  output logic       mosi
);

  localparam int DW = $clog2(HALF + 1);
  localparam logic [DW-1:0] DIV_END = DW'(HALF - 1);

  logic          busy_q, busy_d;
  logic          sclk_q, sclk_d;
  logic          done_q, done_d;
  logic [2:0]    bit_q, bit_d;
  logic [DW-1:0] div_q, div_d;
  logic [7:0]    tx_q, tx_d;
  logic [7:0]    rx_q, rx_d;
  logic          tick;

  assign tick = busy_q && (div_q == DIV_END);

  always_comb begin
    busy_d = busy_q;
    sclk_d = sclk_q;
    done_d = 1'b0;
    bit_d  = bit_q;
    div_d  = div_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      tx_d   = tx_byte;
      div_d  = '0;
      bit_d  = '0;
      sclk_d = 1'b0;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
          rx_d   = {rx_q[6:0], miso};
        end else begin
          sclk_d = 1'b0;
          if (bit_q == 3'd7) begin
            busy_d = 1'b0;
            done_d = 1'b1;
          end else begin
            bit_d = bit_q + 1'b1;
            tx_d  = {tx_q[6:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
      bit_q  <= '0;
      div_q  <= '0;
      tx_q   <= 8'hFF;
      rx_q   <= 8'hFF;
    end else begin
      busy_q <= busy_d;
      sclk_q <= sclk_d;
      done_q <= done_d;
      bit_q  <= bit_d;
      div_q  <= div_d;
      tx_q   <= tx_d;
      rx_q   <= rx_d;
    end
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;
  assign sclk    = sclk_q;
  assign mosi    = tx_q[7];

endmodule

// File: rtl/spi_xact_ctrl.sv
module spi_xact_ctrl
  import spi_xact_pkg::*;
#(
  parameter int MAX_FRAME   = 136,
  parameter int CLK_HALF    = 20,
  parameter int GAP_CYC     = 200000,
  parameter int TIMEOUT_CYC = 60000000
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cmd_wr_en,
  input  logic [$clog2(MAX_FRAME)-1:0]    cmd_wr_addr,
  input  logic [7:0]                      cmd_wr_data,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic [$clog2(MAX_FRAME+2)-1:0]  req_len,
  input  logic [$clog2(MAX_FRAME)-1:0]    rsp_rd_addr,
  output logic [7:0]                      rsp_rd_data,
  output logic [$clog2(MAX_FRAME+2)-1:0]  rsp_len,
  output logic                            done,
  output logic [2:0]                      status,
  output logic                            spi_sclk,
  output logic                            spi_mosi,
  input  logic                            spi_miso,
  output logic                            spi_ss_n
);

  localparam int AW = $clog2(MAX_FRAME);
  localparam int LW = $clog2(MAX_FRAME + 2);
  localparam int TW = $clog2(TIMEOUT_CYC + 1) + 1;
  localparam logic [LW-1:0] MIN_LEN = LW'(2);
  localparam logic [LW-1:0] MAX_LEN = LW'(MAX_FRAME);
  localparam logic [TW-1:0] TMO_END = TW'(TIMEOUT_CYC);

  xact_state_e  state_q, state_d;
  xact_status_e stat_q, stat_d, fin_stat;
  logic          ss_n_q, ss_n_d;
  logic          pend_q, pend_d;
  logic          done_q, done_d;
  logic [AW-1:0] idx_q, idx_d;
  logic [LW-1:0] len_q, len_d;
  logic [LW-1:0] tot_q, tot_d;
  logic [LW-1:0] rlen_q, rlen_d;
  logic [LW-1:0] fin_len;
  logic [7:0]    first_q, first_d;
  logic [TW-1:0] wcnt_q, wcnt_d;
  logic          fin;

  logic          eng_start, eng_busy, eng_done;
  logic [7:0]    eng_tx, eng_rx;
  logic [7:0]    cmd_rd;
  logic          rsp_we;
  logic [AW-1:0] rsp_wa;
  logic          gap_idle;
  logic          accept;
  logic          is_payload;
  logic          last_byte;

  spi_frame_buf #(.DEPTH(MAX_FRAME), .AW(AW)) u_cmd_buf (
    .clk     (clk),
    .wr_en   (cmd_wr_en),
    .wr_addr (cmd_wr_addr),
    .wr_data (cmd_wr_data),
    .rd_addr (idx_q),
    .rd_data (cmd_rd)
  );

  spi_frame_buf #(.DEPTH(MAX_FRAME), .AW(AW)) u_rsp_buf (
    .clk     (clk),
    .wr_en   (rsp_we),
    .wr_addr (rsp_wa),
    .wr_data (eng_rx),
    .rd_addr (rsp_rd_addr),
    .rd_data (rsp_rd_data)
  );

  spi_gap_timer #(.CYC(GAP_CYC)) u_gap (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (fin),
    .idle  (gap_idle)
  );

  spi_byte_engine #(.HALF(CLK_HALF)) u_engine (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (eng_start),
    .tx_byte (eng_tx),
    .miso    (spi_miso),
    .busy    (eng_busy),
    .done    (eng_done),
    .rx_byte (eng_rx),
    .sclk    (spi_sclk),
    .mosi    (spi_mosi)
  );

  assign req_ready  = (state_q == ST_IDLE) && gap_idle && !done_q;
  assign accept     = req_valid && req_ready;
  assign is_payload = (first_q == KIND_BOOT) || (first_q == KIND_PAYLOAD);
  assign last_byte  = (idx_q != AW'(1)) && ((LW'(idx_q) + LW'(1)) == tot_q);
  assign eng_tx     = (state_q == ST_CMD) ? cmd_rd : IDLE_BYTE;
  assign rsp_wa     = (state_q == ST_WAIT) ? '0 : idx_q;
  assign rsp_we     = eng_done &&
                      (((state_q == ST_WAIT) && (eng_rx != IDLE_BYTE)) ||
                       (state_q == ST_RESP));

  always_comb begin
    state_d   = state_q;
    stat_d    = stat_q;
    ss_n_d    = ss_n_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    idx_d     = idx_q;
    len_d     = len_q;
    tot_d     = tot_q;
    rlen_d    = rlen_q;
    first_d   = first_q;
    wcnt_d    = wcnt_q;
    eng_start = 1'b0;
    fin       = 1'b0;
    fin_stat  = XS_OK;
    fin_len   = '0;

    if (state_q != ST_IDLE && !pend_q && !eng_busy) begin
      eng_start = 1'b1;
      pend_d    = 1'b1;
    end
    if (eng_done) begin
      pend_d = 1'b0;
    end

    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_len < MIN_LEN || req_len > MAX_LEN || cmd_rd == IDLE_BYTE) begin
            done_d = 1'b1;
            stat_d = XS_BADREQ;
            rlen_d = '0;
          end else begin
            state_d = ST_CMD;
            ss_n_d  = 1'b0;
            len_d   = req_len;
            idx_d   = '0;
            pend_d  = 1'b0;
          end
        end
      end
      ST_CMD: begin
        if (eng_done) begin
          if ((LW'(idx_q) + LW'(1)) == len_q) begin
            state_d = ST_WAIT;
            idx_d   = '0;
            wcnt_d  = '0;
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (wcnt_q < TMO_END) begin
          wcnt_d = wcnt_q + 1'b1;
        end
        if (eng_done) begin
          if (eng_rx != IDLE_BYTE) begin
            state_d = ST_RESP;
            first_d = eng_rx;
            idx_d   = AW'(1);
            tot_d   = LW'(3);
          end else if (wcnt_q >= TMO_END) begin
            fin      = 1'b1;
            fin_stat = XS_TIMEOUT;
            fin_len  = '0;
          end
        end
      end
      ST_RESP: begin
        if (eng_done) begin
          if (idx_q == AW'(1)) begin
            if (is_payload && eng_rx > MAX_PAYLOAD) begin
              fin      = 1'b1;
              fin_stat = XS_BADTERM;
              fin_len  = LW'(2);
            end else begin
              tot_d = is_payload ? (LW'(eng_rx) + LW'(3)) : LW'(3);
              idx_d = idx_q + 1'b1;
            end
          end else if (last_byte) begin
            fin     = 1'b1;
            fin_len = tot_q;
            if (eng_rx != CLOSE_BYTE) begin
              fin_stat = XS_BADTERM;
            end else if (first_q <= LAST_ERRCODE) begin
              fin_stat = XS_ERRCODE;
            end else begin
              fin_stat = XS_OK;
            end
          end else begin
            idx_d = idx_q + 1'b1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase

    if (fin) begin
      state_d = ST_IDLE;
      ss_n_d  = 1'b1;
      done_d  = 1'b1;
      stat_d  = fin_stat;
      rlen_d  = fin_len;
      idx_d   = '0;
      pend_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      stat_q  <= XS_OK;
      ss_n_q  <= 1'b1;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
      idx_q   <= '0;
      len_q   <= '0;
      tot_q   <= '0;
      rlen_q  <= '0;
      first_q <= 8'hFF;
      wcnt_q  <= '0;
    end else begin
      state_q <= state_d;
      stat_q  <= stat_d;
      ss_n_q  <= ss_n_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
      idx_q   <= idx_d;
      len_q   <= len_d;
      tot_q   <= tot_d;
      rlen_q  <= rlen_d;
      first_q <= first_d;
      wcnt_q  <= wcnt_d;
    end
  end

  assign spi_ss_n = ss_n_q;
  assign done     = done_q;
  assign status   = stat_q;
  assign rsp_len  = rlen_q;

endmodule

// File: rtl/spi_xact_ctrl_chk.sv
module spi_xact_ctrl_chk #(
  parameter int GAP_CYC = 200000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       spi_sclk,
  input logic       spi_mosi,
  input logic       spi_ss_n,
  input logic       req_ready,
  input logic       done,
  input logic [2:0] status
);

  logic [31:0] hi_cnt;
  logic        had_txn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      had_txn <= 1'b0;
    end else begin
      if (!spi_ss_n) begin
        hi_cnt  <= '0;
        had_txn <= 1'b1;
      end else if (hi_cnt != 32'hFFFF_FFFF) begin
        hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  assert_sclk_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    spi_ss_n |-> !spi_sclk);

  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sclk && $past(spi_sclk)) |-> $stable(spi_mosi));

  assert_badreq_noselect_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (done && status == 3'd4) |-> (spi_ss_n && $past(spi_ss_n)));

  assert_ready_deselected_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> spi_ss_n);

  assert_gap_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(spi_ss_n) && had_txn) |-> (hi_cnt >= 32'(GAP_CYC)));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind spi_xact_ctrl spi_xact_ctrl_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .spi_sclk  (spi_sclk),
  .spi_mosi  (spi_mosi),
  .spi_ss_n  (spi_ss_n),
  .req_ready (req_ready),
  .done      (done),
  .status    (status)
);

// File: tb/spi_xact_ctrl_bench.sv
`timescale 1ns/1ps
module spi_xact_ctrl_bench;

  localparam int CLK_HALF = 2;
  localparam int GAP      = 50;
  localparam int TMO      = 400;

  logic       clk;
  logic       rst_n;
  logic       cmd_wr_en;
  logic [7:0] cmd_wr_addr;
  logic [7:0] cmd_wr_data;
  logic       req_valid;
  logic       req_ready;
  logic [7:0] req_len;
  logic [7:0] rsp_rd_addr;
  logic [7:0] rsp_rd_data;
  logic [7:0] rsp_len;
  logic       done;
  logic [2:0] status;
  logic       spi_sclk;
  logic       spi_mosi;
  logic       spi_miso;
  logic       spi_ss_n;

  spi_xact_ctrl #(
    .CLK_HALF    (CLK_HALF),
    .GAP_CYC     (GAP),
    .TIMEOUT_CYC (TMO)
  ) u_spi_xact_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_wr_en   (cmd_wr_en),
    .cmd_wr_addr (cmd_wr_addr),
    .cmd_wr_data (cmd_wr_data),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_len     (req_len),
    .rsp_rd_addr (rsp_rd_addr),
    .rsp_rd_data (rsp_rd_data),
    .rsp_len     (rsp_len),
    .done        (done),
    .status      (status),
    .spi_sclk    (spi_sclk),
    .spi_mosi    (spi_mosi),
    .spi_miso    (spi_miso),
    .spi_ss_n    (spi_ss_n)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // peer model: mode 0, drives MISO on falling SCLK, samples MOSI on rising SCLK
  logic [7:0] script [0:299];
  logic [7:0] mo     [0:299];
  logic [7:0] sh;
  logic [7:0] rxs;
  int sidx, nb, bitn;
  logic miso_r = 1'b1;
  assign spi_miso = miso_r;

  always @(negedge spi_ss_n) begin
    sidx = 0; nb = 0; bitn = 0;
    sh = script[0];
    miso_r = sh[7];
  end
  always @(posedge spi_sclk) if (!spi_ss_n) rxs = {rxs[6:0], spi_mosi};
  always @(negedge spi_sclk) begin
    if (!spi_ss_n) begin
      bitn++;
      if (bitn == 8) begin
        if (nb < 300) mo[nb] = rxs;
        nb++;
        bitn = 0;
        if (sidx < 299) sidx++;
        sh = script[sidx];
      end else begin
        sh = {sh[6:0], 1'b1};
      end
      miso_r = sh[7];
    end
  end

  // monitors sampled on falling system clock
  int hi_run = 0, last_hi = 0, ss_falls = 0;
  int since_rise = 1000, min_rise = 1000, cyc = 0;
  logic prev_ss = 1'b1, prev_sclk = 1'b0;
  bit wd_fired = 0;

  always @(negedge clk) begin
    cyc++;
    if (spi_ss_n) hi_run++;
    else begin
      if (prev_ss) begin last_hi = hi_run; ss_falls++; end
      hi_run = 0;
    end
    prev_ss = spi_ss_n;
    since_rise++;
    if (spi_sclk && !prev_sclk) begin
      if (since_rise < min_rise) min_rise = since_rise;
      since_rise = 0;
    end
    prev_sclk = spi_sclk;
    if (cyc > 150000 && !wd_fired) begin
      wd_fired = 1;
      checks++; fails++;
      $display("FAIL watchdog all-R actual=%0d expected<150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  logic [7:0] cmd_arr [0:139];

  task automatic clear_script();
    for (int i = 0; i < 300; i++) script[i] = 8'hFF;
  endtask

  task automatic write_cmd(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_wr_en   = 1'b1;
      cmd_wr_addr = 8'(i);
      cmd_wr_data = cmd_arr[i];
    end
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  task automatic issue(input int len);
    @(negedge clk);
    req_len   = 8'(len);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 20000) begin @(negedge clk); n++; end
    chk({req, " done seen"}, int'(done), 1);
  endtask

  task automatic chk_rsp(input string req, input int idx, input logic [7:0] exp);
    rsp_rd_addr = 8'(idx);
    #1;
    chk(req, int'(rsp_rd_data), int'(exp));
  endtask

  task automatic t_reset();
    chk("R1 reset ss_n", int'(spi_ss_n), 1);
    chk("R1 reset sclk", int'(spi_sclk), 0);
    chk("R11 reset done", int'(done), 0);
    chk("R9 reset ready", int'(req_ready), 1);
  endtask

  task automatic t_version();
    clear_script();
    script[0] = 8'h33; script[1] = 8'h44;            // R3 junk during command
    script[5] = 8'h82; script[6] = 8'h05; script[7] = 8'hA7;
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R11");
    chk("R11 status ok", int'(status), 0);
    chk("R6 short length", int'(rsp_len), 3);
    @(negedge clk);
    chk("R11 done one cycle", int'(done), 0);
    chk_rsp("R4 first response byte", 0, 8'h82);
    chk_rsp("R11 byte1", 1, 8'h05);
    chk_rsp("R11 byte2", 2, 8'hA7);
    chk("R1 MSB first cmd0", int'(mo[0]), 8'h0A);
    chk("R1 cmd1", int'(mo[1]), 8'hA7);
    chk("R4 poll byte", int'(mo[2]), 8'hFF);
    chk("R3 total bytes clocked", nb, 8);
    chk("R1 sclk rise spacing", min_rise, 2 * CLK_HALF);
  endtask

  task automatic t_payload();
    clear_script();
    for (int i = 0; i < 7; i++) script[i] = 8'h00;   // R3 non-idle junk
    script[8]  = 8'hFE; script[9]  = 8'h07; script[10] = 8'h00; script[11] = 8'h80;
    script[12] = 8'h00; script[13] = 8'h04; script[14] = 8'h02; script[15] = 8'h10;
    script[16] = 8'h45; script[17] = 8'hA7;
    cmd_arr[0] = 8'hFE; cmd_arr[1] = 8'h04; cmd_arr[2] = 8'h00; cmd_arr[3] = 8'h00;
    cmd_arr[4] = 8'h00; cmd_arr[5] = 8'h04; cmd_arr[6] = 8'hA7;
    write_cmd(7);
    issue(7);
    wait_done("R6");
    chk("R6 payload status", int'(status), 0);
    chk("R6 payload length L+3", int'(rsp_len), 10);
    @(negedge clk);
    chk_rsp("R3 first byte not junk", 0, 8'hFE);
    chk_rsp("R6 last byte", 9, 8'hA7);
    chk("R6 bytes clocked", nb, 18);
  endtask

  task automatic t_errcode();
    clear_script();
    script[3] = 8'h02; script[4] = 8'h00; script[5] = 8'hA7;
    cmd_arr[0] = 8'h0B; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R8");
    chk("R8 error status", int'(status), 1);
    chk("R8 length", int'(rsp_len), 3);
    @(negedge clk);
    chk_rsp("R8 code byte", 0, 8'h02);
    chk("R8 full frame clocked", nb, 6);
  endtask

  task automatic t_badterm();
    clear_script();
    script[2] = 8'h81; script[3] = 8'h01; script[4] = 8'h00;
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R7");
    chk("R7 bad terminator status", int'(status), 2);
    @(negedge clk);
  endtask

  task automatic t_timeout();
    clear_script();
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R5");
    chk("R5 timeout status", int'(status), 3);
    chk("R5 length zero", int'(rsp_len), 0);
    chk("R5 polled beyond limit", int'(nb >= 2 + TMO / (2 * CLK_HALF * 8 + 2)), 1);
    @(negedge clk);
    chk("R5 select released", int'(spi_ss_n), 1);
  endtask

  task automatic t_oversize();
    clear_script();
    script[2] = 8'hFE; script[3] = 8'h86;
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R10");
    chk("R10 corrupt status", int'(status), 2);
    chk("R10 length two", int'(rsp_len), 2);
    @(negedge clk);
    chk("R10 stopped after length byte", nb, 4);
  endtask

  task automatic t_badreq();
    int f0 = ss_falls;
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(1);
    chk("R2 short request done", int'(done), 1);
    chk("R2 short request status", int'(status), 4);
    issue(137);
    chk("R2 long request done", int'(done), 1);
    chk("R2 long request status", int'(status), 4);
    cmd_arr[0] = 8'hFF;
    write_cmd(1);
    issue(2);
    chk("R2 idle first byte done", int'(done), 1);
    chk("R2 idle first byte status", int'(status), 4);
    chk("R2 select never asserted", ss_falls, f0);
  endtask

  task automatic t_gap();
    int cnt = 0;
    clear_script();
    script[2] = 8'hFD; script[3] = 8'h03; script[4] = 8'h11;
    script[5] = 8'h22; script[6] = 8'h33; script[7] = 8'hA7;
    cmd_arr[0] = 8'h0A; cmd_arr[1] = 8'hA7;
    write_cmd(2);
    issue(2);
    wait_done("R9");
    chk("R6 boot frame length", int'(rsp_len), 6);
    chk("R9 ready low at done", int'(req_ready), 0);
    while (!req_ready && cnt < 1000) begin @(negedge clk); cnt++; end
    chk("R9 ready after gap", cnt, GAP);
    issue(2);
    wait_done("R9");
    chk("R9 select high interval", int'(last_hi >= GAP), 1);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; cmd_wr_en = 1'b0; cmd_wr_addr = '0; cmd_wr_data = '0;
    req_valid = 1'b0; req_len = '0; rsp_rd_addr = '0;
    clear_script();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_version();
    t_payload();
    t_errcode();
    t_badterm();
    t_timeout();
    t_oversize();
    t_badreq();
    t_gap();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule